// File: doc/BRIEF.md
# Per-Core Banked Register Window

This block holds a small bank of registers for each core of a multi-core cluster and lets any core reach them through two address windows. A request carries the index of the core that issued it. In the local window, that index picks the bank. In the remote window, the bank comes from a pointer register. That pointer lives in the requester's own bank and is called the peer pointer. Software uses the remote window to set up or inspect another core's interrupt routing without running on that core.

Each bank holds:

- a control word that is always zero;
- a single compare-pending flag, set by an external compare-match strobe;
- a six-bit interrupt-enable mask, changed only through separate set and clear offsets;
- a compare-routing word, holding a pin number and a route-to-pin flag;
- the peer pointer;
- a compare value, which the block copies out to an external timer each time it is written.

Reads return data one cycle after the request. Timer counting is not part of this block.

The address is a word index. Bit 4 selects the window: 0 is local and 1 is remote. Bits 3:0 select the register:

| Offset | Register |
|---|---|
| 0 | control |
| 1 | pending |
| 2 | mask (read) |
| 3 | mask clear |
| 4 | mask set |
| 5 | compare routing |
| 6 | peer pointer |
| 7 | identity |
| 8 | compare low word |
| 9 | compare high word |
| 10 to 15 | unimplemented |

Top module: `core_bank_window`

## Requirements
- R1: A local-window access (address bit 4 = 0) addresses the bank of `req_core`. A remote-window access (bit 4 = 1) addresses the bank named by the peer pointer stored in `req_core`'s bank, using the value held before that cycle's write.
- R2: A read of offset 7 returns the index of the bank actually addressed, zero-extended.
- R3: A write to offset 6 stores the value as the peer pointer only when the full 32-bit value is less than NUM_CORES. Any other value leaves the pointer unchanged.
- R4: A write to offset 4 sets the mask bits that are 1 in data bits 5:0. A write to offset 3 clears them. Data bits 31:6 have no effect, and mask bits 31:6 always read zero.
- R5: Writes to offset 0 are ignored, and offset 0 always reads zero.
- R6: A write to offset 5 is discarded when data bits 5:0 exceed 5. Otherwise the word stored is the data ANDed with 0x8000003F: pin field in bits 5:0, route-to-pin flag in bit 31.
- R7: A write to offset 8 stores the compare value for the addressed bank, which reads back at offset 8. In the next cycle the block presents it on `cmp_wr_data`, with `cmp_wr_valid` high for exactly one cycle and `cmp_wr_core` set to the bank index.
- R8: Offset 1 reads the compare-pending flag in bit 1, and all other bits read zero. `cmp_hit[i]` sets the flag of bank i, and a write to offset 8 of that bank clears it. When both happen in the same cycle, the strobe wins.
- R9: Offset 9 always reads zero, and writes to it are ignored.
- R10: Offsets 10 to 15 read zero and ignore writes. The write-only offsets 3 and 4 also read zero.
- R11: After reset, every bank holds control 0, pending 0, mask 0x32, routing 0x80000000, peer pointer 0 and compare value 0xFFFFFFFF.
- R12: `rsp_valid` is high in the cycle after a read request and low otherwise. `rsp_rdata` carries the read value in that cycle and is zero in any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_core | input | CORE_W | Index of the requesting core |
| req_addr | input | 5 | Bit 4 window select, bits 3:0 register offset |
| req_wdata | input | 32 | Write data |
| cmp_hit | input | NUM_CORES | Per-core compare-match strobe |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| cmp_wr_valid | output | 1 | Compare value forwarded this cycle |
| cmp_wr_core | output | CORE_W | Bank whose compare value was written |
| cmp_wr_data | output | 32 | Forwarded compare value |

## Verification
The assertions check, on every cycle, the following invariants:

- the read response timing;
- zero reads from the control and compare high-word offsets;
- the identity value returned through the local window;
- the forwarding of each compare write;
- the limits that stored peer pointers and routing pin fields never leave.

Only the bench's scenarios can show the rest. This covers remote-window redirection through a freshly written pointer, the rejection of pointer and routing values that are out of range, and the mask arithmetic through set and clear. It also covers the race between a compare-match strobe and a compare write in the same cycle, and the reset contents of every bank. The bench shows these by comparing every response against a reference model.

// File: rtl/cpw_pkg.sv
package cpw_pkg;

    localparam int WORD_W   = 32;
    localparam int OFF_W    = 4;
    localparam int ADDR_W   = OFF_W + 1;
    localparam int MASK_W   = 6;
    localparam int PIN_W    = 6;
    localparam int PIN_MAX  = 5;
    localparam int PEND_BIT = 1;

    localparam logic [MASK_W-1:0] MASK_RESET = 6'h32;
    localparam logic [WORD_W-1:0] CMP_RESET  = 32'hFFFF_FFFF;

    typedef enum logic [OFF_W-1:0] {
        REG_CTRL     = 4'd0,
        REG_PEND     = 4'd1,
        REG_MASK     = 4'd2,
        REG_MASK_CLR = 4'd3,
        REG_MASK_SET = 4'd4,
        REG_ROUTE    = 4'd5,
        REG_PEER     = 4'd6,
        REG_WHOAMI   = 4'd7,
        REG_CMP_LO   = 4'd8,
        REG_CMP_HI   = 4'd9,
        REG_NONE     = 4'd15
    } reg_kind_e;

    typedef struct packed {
        logic              cmp_pend;
        logic [MASK_W-1:0] mask;
        logic              route_flag;
        logic [PIN_W-1:0]  route_pin;
        logic [WORD_W-1:0] cmp;
    } bank_state_t;

    function automatic reg_kind_e off_kind(input logic [OFF_W-1:0] off);
        reg_kind_e k;
        case (off)
            4'd0:    k = REG_CTRL;
            4'd1:    k = REG_PEND;
            4'd2:    k = REG_MASK;
            4'd3:    k = REG_MASK_CLR;
            4'd4:    k = REG_MASK_SET;
            4'd5:    k = REG_ROUTE;
            4'd6:    k = REG_PEER;
            4'd7:    k = REG_WHOAMI;
            4'd8:    k = REG_CMP_LO;
            4'd9:    k = REG_CMP_HI;
            default: k = REG_NONE;
        endcase
        return k;
    endfunction

    function automatic logic route_ok(input logic [WORD_W-1:0] d);
        return int'(d[PIN_W-1:0]) <= PIN_MAX;
    endfunction

endpackage

// File: rtl/cpw_decode.sv
module cpw_decode import cpw_pkg::*; #(
    parameter int NUM_CORES = 4,
    parameter int CORE_W    = 2
) (
    input  logic                              req_valid,
    input  logic                              req_write,
    input  logic [CORE_W-1:0]                 req_core,
    input  logic [ADDR_W-1:0]                 req_addr,
    input  logic [NUM_CORES-1:0][CORE_W-1:0]  peer_vec,
    output logic [CORE_W-1:0]                 bank_idx,
    output reg_kind_e                         kind,
    output logic [NUM_CORES-1:0]              wr_sel,
    output logic                              rd_en
);

    logic remote;

    always_comb begin
        remote   = req_addr[ADDR_W-1];
        // R1: remote window follows the requester's peer pointer
        bank_idx = remote ? peer_vec[req_core] : req_core;
        kind     = off_kind(req_addr[OFF_W-1:0]);
        rd_en    = req_valid && !req_write;
        for (int i = 0; i < NUM_CORES; i++) begin
            wr_sel[i] = req_valid && req_write && (bank_idx == CORE_W'(i));
        end
    end

endmodule

// File: rtl/cpw_bank.sv
module cpw_bank import cpw_pkg::*; #(
    parameter int NUM_CORES = 4,
    parameter int CORE_W    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_kind_e         kind,
    input  logic [WORD_W-1:0] wdata,
    input  logic              hit,
    output bank_state_t       st,
    output logic [CORE_W-1:0] peer
);

    logic peer_ok;
    assign peer_ok = wdata < WORD_W'(NUM_CORES);

    always_ff @(posedge clk) begin
        if (rst) begin
            st.cmp_pend   <= 1'b0;
            st.mask       <= MASK_RESET;
            st.route_flag <= 1'b1;
            st.route_pin  <= '0;
            st.cmp        <= CMP_RESET;
            peer          <= '0;
        end else begin
            if (wr_en) begin
                case (kind)
                    REG_MASK_CLR: st.mask <= st.mask & ~wdata[MASK_W-1:0];
                    REG_MASK_SET: st.mask <= st.mask | wdata[MASK_W-1:0];
                    REG_ROUTE: begin
                        if (route_ok(wdata)) begin
                            st.route_pin  <= wdata[PIN_W-1:0];
                            st.route_flag <= wdata[WORD_W-1];
                        end
                    end
                    REG_PEER: begin
                        if (peer_ok) begin
                            peer <= wdata[CORE_W-1:0];
                        end
                    end
                    REG_CMP_LO: st.cmp <= wdata;
                    default: ;
                endcase
            end
            // R8: a match strobe outranks the clear from a compare write
            if (hit) begin
                st.cmp_pend <= 1'b1;
            end else if (wr_en && kind == REG_CMP_LO) begin
                st.cmp_pend <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cpw_rdmux.sv
module cpw_rdmux import cpw_pkg::*; #(
    parameter int NUM_CORES = 4,
    parameter int CORE_W    = 2
) (
    input  bank_state_t [NUM_CORES-1:0]       st_vec,
    input  logic [NUM_CORES-1:0][CORE_W-1:0]  peer_vec,
    input  logic [CORE_W-1:0]                 bank_idx,
    input  reg_kind_e                         kind,
    output logic [WORD_W-1:0]                 rd_word
);

    bank_state_t sel;

    always_comb begin
        sel = st_vec[bank_idx];
        case (kind)
            REG_PEND:   rd_word = WORD_W'(sel.cmp_pend) << PEND_BIT;
            REG_MASK:   rd_word = WORD_W'(sel.mask);
            REG_ROUTE:  rd_word = {sel.route_flag, {(WORD_W-1-PIN_W){1'b0}}, sel.route_pin};
            REG_PEER:   rd_word = WORD_W'(peer_vec[bank_idx]);
            REG_WHOAMI: rd_word = WORD_W'(bank_idx);
            REG_CMP_LO: rd_word = sel.cmp;
            default:    rd_word = '0;
        endcase
    end

endmodule

// File: rtl/core_bank_window.sv
module core_bank_window import cpw_pkg::*; #(
    parameter  int NUM_CORES = 4,
    localparam int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [CORE_W-1:0]    req_core,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [WORD_W-1:0]    req_wdata,
    input  logic [NUM_CORES-1:0] cmp_hit,
    output logic                 rsp_valid,
    output logic [WORD_W-1:0]    rsp_rdata,
    output logic                 cmp_wr_valid,
    output logic [CORE_W-1:0]    cmp_wr_core,
    output logic [WORD_W-1:0]    cmp_wr_data
);

    bank_state_t [NUM_CORES-1:0]      st_vec;
    logic [NUM_CORES-1:0][CORE_W-1:0] peer_vec;
    logic [CORE_W-1:0]                bank_idx;
    reg_kind_e                        kind;
    logic [NUM_CORES-1:0]             wr_sel;
    logic                             rd_en;
    logic [WORD_W-1:0]                rd_word;

    cpw_decode #(.NUM_CORES(NUM_CORES), .CORE_W(CORE_W)) dec_i (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_core  (req_core),
        .req_addr  (req_addr),
        .peer_vec  (peer_vec),
        .bank_idx  (bank_idx),
        .kind      (kind),
        .wr_sel    (wr_sel),
        .rd_en     (rd_en)
    );

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_bank
        cpw_bank #(.NUM_CORES(NUM_CORES), .CORE_W(CORE_W)) bank_i (
            .clk   (clk),
            .rst   (rst),
            .wr_en (wr_sel[g]),
            .kind  (kind),
            .wdata (req_wdata),
            .hit   (cmp_hit[g]),
            .st    (st_vec[g]),
            .peer  (peer_vec[g])
        );
    end

    cpw_rdmux #(.NUM_CORES(NUM_CORES), .CORE_W(CORE_W)) mux_i (
        .st_vec   (st_vec),
        .peer_vec (peer_vec),
        .bank_idx (bank_idx),
        .kind     (kind),
        .rd_word  (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid    <= 1'b0;
            rsp_rdata    <= '0;
            cmp_wr_valid <= 1'b0;
            cmp_wr_core  <= '0;
            cmp_wr_data  <= '0;
        end else begin
            rsp_valid    <= rd_en;
            rsp_rdata    <= rd_en ? rd_word : '0;
            cmp_wr_valid <= req_valid && req_write && kind == REG_CMP_LO;
            cmp_wr_core  <= bank_idx;
            cmp_wr_data  <= req_wdata;
        end
    end

endmodule

// File: rtl/core_bank_window_chk.sv
module core_bank_window_chk import cpw_pkg::*; #(
    parameter int NUM_CORES = 4,
    parameter int CORE_W    = 2
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             req_valid,
    input logic                             req_write,
    input logic [CORE_W-1:0]                req_core,
    input logic [ADDR_W-1:0]                req_addr,
    input logic [WORD_W-1:0]                req_wdata,
    input logic                             rsp_valid,
    input logic [WORD_W-1:0]                rsp_rdata,
    input logic                             cmp_wr_valid,
    input logic [WORD_W-1:0]                cmp_wr_data,
    input bank_state_t [NUM_CORES-1:0]      st_vec,
    input logic [NUM_CORES-1:0][CORE_W-1:0] peer_vec
);

    logic is_rd;
    logic [OFF_W-1:0] off;
    assign is_rd = req_valid && !req_write;
    assign off   = req_addr[OFF_W-1:0];

    // R12
    rd_resp_chk: assert property (@(posedge clk) disable iff (rst)
        is_rd |=> rsp_valid);

    // R12
    idle_resp_chk: assert property (@(posedge clk) disable iff (rst)
        !is_rd |=> (!rsp_valid && rsp_rdata == '0));

    // R5
    ctrl_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (is_rd && off == OFF_W'(REG_CTRL)) |=> rsp_rdata == '0);

    // R9
    cmp_hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (is_rd && off == OFF_W'(REG_CMP_HI)) |=> rsp_rdata == '0);

    // R2
    whoami_local_chk: assert property (@(posedge clk) disable iff (rst)
        (is_rd && !req_addr[ADDR_W-1] && off == OFF_W'(REG_WHOAMI))
        |=> rsp_rdata == WORD_W'($past(req_core)));

    // R7
    cmp_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && off == OFF_W'(REG_CMP_LO))
        |=> (cmp_wr_valid && cmp_wr_data == $past(req_wdata)));

    // R7
    cmp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_write && off == OFF_W'(REG_CMP_LO)) |=> !cmp_wr_valid);

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_bank_chk
        // R3
        peer_range_chk: assert property (@(posedge clk) disable iff (rst)
            int'(peer_vec[g]) < NUM_CORES);

        // R6
        route_pin_chk: assert property (@(posedge clk) disable iff (rst)
            int'(st_vec[g].route_pin) <= PIN_MAX);
    end

endmodule

bind core_bank_window core_bank_window_chk #(.NUM_CORES(NUM_CORES), .CORE_W(CORE_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_core     (req_core),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .rsp_valid    (rsp_valid),
    .rsp_rdata    (rsp_rdata),
    .cmp_wr_valid (cmp_wr_valid),
    .cmp_wr_data  (cmp_wr_data),
    .st_vec       (st_vec),
    .peer_vec     (peer_vec)
);

// File: tb/core_bank_window_tb.sv
`timescale 1ns/1ps
module core_bank_window_tb_top;

    localparam int NC = 4;
    localparam int CW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [CW-1:0] req_core = '0;
    logic [4:0]    req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic [NC-1:0] cmp_hit = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic          cmp_wr_valid;
    logic [CW-1:0] cmp_wr_core;
    logic [31:0]   cmp_wr_data;

    core_bank_window #(.NUM_CORES(NC)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_core(req_core), .req_addr(req_addr), .req_wdata(req_wdata),
        .cmp_hit(cmp_hit), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .cmp_wr_valid(cmp_wr_valid), .cmp_wr_core(cmp_wr_core),
        .cmp_wr_data(cmp_wr_data)
    );

    always #2 clk = ~clk;

    // reference model state
    logic [31:0] m_mask [NC];
    logic [31:0] m_route[NC];
    logic [31:0] m_cmp  [NC];
    int          m_peer [NC];
    bit          m_pend [NC];

    bit          e_valid;
    logic [31:0] e_rdata;
    bit          e_cv;
    logic [31:0] e_cc;
    logic [31:0] e_cd;
    string       e_tag = "R11";
    string       tag_ovr = "";
    bit          model_ready = 1'b0;
    bit          done = 1'b0;
    int          checks = 0;
    int          fails = 0;
    int          cycles = 0;
    int          b;
    logic [3:0]  off;
    logic [31:0] wd;

    function automatic string tag_for(input logic [3:0] o, input logic remote);
        if (remote) return "R1";
        case (o)
            4'd0: return "R5";
            4'd1: return "R8";
            4'd2: return "R4";
            4'd5: return "R6";
            4'd6: return "R3";
            4'd7: return "R2";
            4'd8: return "R7";
            4'd9: return "R9";
            default: return "R10";
        endcase
    endfunction

    always @(posedge clk) begin
        model_ready = 1'b1;
        if (rst) begin
            for (int i = 0; i < NC; i++) begin
                m_mask[i] = 32'h32; m_route[i] = 32'h8000_0000;
                m_cmp[i] = 32'hFFFF_FFFF; m_peer[i] = 0; m_pend[i] = 1'b0;
            end
            e_valid = 0; e_rdata = 0; e_cv = 0; e_cc = 0; e_cd = 0;
        end else begin
            b   = req_addr[4] ? m_peer[req_core] : int'(req_core);
            off = req_addr[3:0];
            wd  = req_wdata;
            e_valid = req_valid && !req_write;
            e_rdata = 0; e_cv = 0; e_cc = 0; e_cd = 0;
            e_tag = (tag_ovr != "") ? tag_ovr : tag_for(off, req_addr[4]);
            if (e_valid) begin
                case (off)
                    4'd1: e_rdata = m_pend[b] ? 32'h2 : 32'h0;
                    4'd2: e_rdata = m_mask[b];
                    4'd5: e_rdata = m_route[b];
                    4'd6: e_rdata = 32'(m_peer[b]);
                    4'd7: e_rdata = 32'(b);
                    4'd8: e_rdata = m_cmp[b];
                    default: e_rdata = 0;
                endcase
            end
            if (req_valid && req_write) begin
                case (off)
                    4'd3: m_mask[b] = m_mask[b] & ~(wd & 32'h3F);
                    4'd4: m_mask[b] = m_mask[b] | (wd & 32'h3F);
                    4'd5: if (wd[5:0] <= 6'd5) m_route[b] = wd & 32'h8000_003F;
                    4'd6: if (wd < 32'(NC)) m_peer[b] = int'(wd);
                    4'd8: begin
                        m_cmp[b] = wd; m_pend[b] = 1'b0;
                        e_cv = 1; e_cc = 32'(b); e_cd = wd;
                    end
                    default: ;
                endcase
            end
            for (int i = 0; i < NC; i++) if (cmp_hit[i]) m_pend[i] = 1'b1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at %0t: actual 0x%08h expected 0x%08h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (model_ready && !done && !rst) begin
            chk(rsp_valid == e_valid, "R12", 32'(rsp_valid), 32'(e_valid));
            chk(rsp_rdata == e_rdata, e_tag, rsp_rdata, e_rdata);
            chk(cmp_wr_valid == e_cv && (!e_cv || (32'(cmp_wr_core) == e_cc &&
                cmp_wr_data == e_cd)), "R7", cmp_wr_valid ? cmp_wr_data : 32'h0,
                e_cv ? e_cd : 32'h0);
        end
    end

    task automatic report();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 20000 && !done) begin
            fails++;
            $display("FAIL R12 watchdog: actual %0d cycles expected completion", cycles);
            report();
        end
    end

    task automatic op(input int core, input bit remote, input int o, input bit wr,
                      input logic [31:0] d, input logic [NC-1:0] hit);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_core = CW'(core);
        req_addr = {remote, 4'(o)}; req_wdata = d; cmp_hit = hit;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; cmp_hit = '0;
    endtask

    logic [31:0] lf = 32'h1ACE_B00C;
    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] t = s;
        t ^= t << 13; t ^= t >> 17; t ^= t << 5;
        return t;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11: reset contents of every bank
        tag_ovr = "R11";
        for (int c = 0; c < NC; c++) begin
            op(c, 0, 0, 0, 0, 0); op(c, 0, 1, 0, 0, 0); op(c, 0, 2, 0, 0, 0);
            op(c, 0, 5, 0, 0, 0); op(c, 0, 6, 0, 0, 0); op(c, 0, 8, 0, 0, 0);
        end
        tag_ovr = "";
        // R5: control ignores writes
        op(0, 0, 0, 1, 32'hFFFF_FFFF, 0); op(0, 0, 0, 0, 0, 0);
        // R4: set and clear
        op(1, 0, 4, 1, 32'hFFFF_FFC1, 0); op(1, 0, 2, 0, 0, 0);
        op(1, 0, 3, 1, 32'h0000_0022, 0); op(1, 0, 2, 0, 0, 0);
        // R3: out-of-range pointer values rejected
        op(0, 0, 6, 1, 4, 0); op(0, 0, 6, 0, 0, 0);
        op(0, 0, 6, 1, 32'hFFFF_0002, 0); op(0, 0, 6, 0, 0, 0);
        op(0, 0, 6, 1, 2, 0); op(0, 0, 6, 0, 0, 0);
        // R1 R2: remote window redirect
        op(0, 1, 7, 0, 0, 0); op(0, 1, 4, 1, 32'h0C, 0);
        op(2, 0, 2, 0, 0, 0); op(3, 0, 7, 0, 0, 0);
        // R6: routing checks
        op(2, 0, 5, 1, 32'h8000_0006, 0); op(2, 0, 5, 0, 0, 0);
        op(2, 0, 5, 1, 32'h7FFF_FF05, 0); op(2, 0, 5, 0, 0, 0);
        op(2, 0, 5, 1, 32'h8000_0003, 0); op(2, 0, 5, 0, 0, 0);
        // R8 R7: pending set, cleared by compare write, strobe wins a tie
        op(3, 0, 1, 0, 0, 4'b1000); op(3, 0, 1, 0, 0, 0);
        op(3, 0, 8, 1, 32'h0000_1234, 0); op(3, 0, 1, 0, 0, 0);
        op(3, 0, 8, 0, 0, 0);
        op(3, 0, 8, 1, 32'hCAFE_0001, 4'b1000); op(3, 0, 1, 0, 0, 0);
        op(0, 1, 8, 1, 32'h5555_AAAA, 0); op(2, 0, 8, 0, 0, 0);
        // R9 R10: high word and holes
        op(1, 0, 9, 1, 32'hDEAD_BEEF, 0); op(1, 0, 9, 0, 0, 0);
        op(1, 0, 12, 1, 32'hFFFF_FFFF, 0); op(1, 0, 12, 0, 0, 0);
        op(1, 0, 15, 0, 0, 0); op(1, 0, 4, 0, 0, 0); op(1, 0, 3, 0, 0, 0);
        op(1, 0, 2, 0, 0, 0);
        idle();
        // mixed traffic against the model
        for (int n = 0; n < 600; n++) begin
            logic [31:0] d;
            lf = nxt(lf);
            d  = lf[7] ? (nxt(lf) & 32'h7) : nxt(lf);
            op(int'(lf[1:0]), lf[20], int'(lf[19:16]), lf[21], d,
               (lf[15:12] == 4'd0) ? lf[27:24] : 4'd0);
        end
        idle();
        idle();
        @(posedge clk);
        #1;
        report();
    end

endmodule